// File: doc/BRIEF.md
# SPI Serial Memory Command Sequencer

This block is an SPI master (mode 0) that moves a burst of bytes between a host and a serial nonvolatile memory. The host presents one request, made of a write/read flag, a 32-bit start address, a byte count and the address format, and the block then produces the complete chip-select, clock and MOSI sequence by itself. Write data enters through a valid/ready input stream. Read data leaves through a valid/ready output stream. A one-cycle done pulse marks the end of the request and carries the number of data bytes moved.

A write is sent as two bus frames. The first frame holds only the write-enable opcode. Chip-select then stays high for a programmable gap, and the second frame carries the write opcode, the address and the data. A read is sent as one frame: opcode, address, then the data clocked in. The address takes 1 to 4 bytes. A compact mode for 512-byte parts moves address bit 8 into the opcode so that only one address byte is sent. When a stream stalls, SCK stops between bytes and chip-select stays low.

Top module: `nvm_spi_seq`

## Requirements
- R1: Opcodes go out MSB first. The values are write-enable 0x06, write 0x02 and read 0x03. Every byte on MOSI is sampled by the memory on a rising SCK edge.
- R2: A write sends a frame that holds only 0x06. Chip-select then stays high for at least GAP_CYCLES clock cycles before the frame that starts with the write opcode.
- R3: A read sends no write-enable frame. It sends one frame: read opcode, address bytes, then the data bytes. MOSI carries 0x00 during each read data byte.
- R4: The address follows the opcode as cfg_addr_m1+1 bytes (cfg_addr_m1 is 0 to 3). These are the low-order bytes of req_addr, sent most significant byte first.
- R5: Compact mode applies when cfg_compact=1 and cfg_addr_m1=0. In this mode the opcode has bit 3 (0x08) set when req_addr > 0xFF, and one address byte, req_addr[7:0], follows. When cfg_compact=0 the opcode is never changed.
- R6: Chip-select stays low through all req_len data bytes and goes high after the last one. done pulses for one cycle while chip-select is high, and done_count equals the number of data bytes transferred.
- R7: A request with req_len=0 sends the opcode and the address bytes, then raises chip-select and pulses done with done_count=0.
- R8: SPI mode 0: SCK is low whenever chip-select is high, and each SCK level lasts CLK_DIV clock cycles within a byte. MOSI changes only while SCK is low. MISO is captured on the rising SCK edge, and each read byte is presented on rd_data.
- R9: When wr_valid is low or rd_ready is low, SCK stops between bytes and chip-select stays low. rd_data and rd_valid stay unchanged until rd_ready is high.
- R10: A request is accepted only while req_ready is high, which is only in the idle state. req_valid during a transfer has no effect. Chip-select stays high for at least GAP_CYCLES cycles between two requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 32 | Start address in the memory |
| req_len | input | CNT_W | Number of data bytes |
| cfg_addr_m1 | input | 2 | Number of address bytes minus one |
| cfg_compact | input | 1 | Compact 9-bit addressing when one address byte is used |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Data bytes moved by the finished request |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The hardest situation to reach is a stall in the middle of a burst while chip-select is low. The stream must hold off exactly when one byte has finished and the next has not yet started. The bench reaches it by keeping rd_ready low while the first read byte is pending, and by keeping wr_valid low for a long window after the first write byte is taken. It then checks that no SCK edge occurs and that chip-select stays low. A second case is a request that is offered while the block is busy, or right after done. For this the bench keeps req_valid high with different parameters for the whole transfer, and checks that no extra frame appears.

// File: rtl/nvm_spi_pkg.sv
package nvm_spi_pkg;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_HIBIT = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_WGAP,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic        is_write;
        logic        compact;
        logic [1:0]  addr_m1;
        logic [31:0] addr;
    } req_hdr_t;

    function automatic logic [7:0] pick_opcode(req_hdr_t h);
        logic [7:0] op;
        op = h.is_write ? OPC_WRITE : OPC_READ;
        if (h.compact && (h.addr > 32'h0000_00FF))
            op = op | OPC_HIBIT;
        return op;
    endfunction

    function automatic logic [7:0] addr_byte(logic [31:0] a, logic [1:0] idx);
        return a[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/nvm_spi_halftick.sv
module nvm_spi_halftick #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/nvm_spi_shifter.sv
module nvm_spi_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    logic       busy_q;
    logic [7:0] sh_q;
    logic [2:0] bit_q;
    logic       tick;

    nvm_spi_halftick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (busy_q),
        .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sh_q   <= '0;
            bit_q  <= '0;
            sck    <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                sh_q   <= tx;
                bit_q  <= '0;
                sck    <= 1'b0;
            end else if (busy_q && tick) begin
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = busy_q & sh_q[7];

    // A byte always ends with the clock back low (mode 0 idle level)
    assert_byte_ends_low_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !sck);
    // The clock is only ever high inside a running byte
    assert_sck_in_byte_R8: assert property (@(posedge clk) disable iff (rst)
        sck |-> busy_q);
endmodule

// File: rtl/nvm_spi_seq.sv
module nvm_spi_seq
    import nvm_spi_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int CLK_DIV    = 2,
    parameter int GAP_CYCLES = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [31:0]      req_addr,
    input  logic [CNT_W-1:0] req_len,
    input  logic [1:0]       cfg_addr_m1,
    input  logic             cfg_compact,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             done,
    output logic [CNT_W-1:0] done_count,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(GAP_CYCLES);

    seq_state_e       state_q;
    req_hdr_t         hdr_q;
    logic [CNT_W-1:0] len_q, cnt_q, cnt_inc;
    logic [1:0]       idx_q;
    logic [GW-1:0]    gap_q;
    logic             inflight_q;
    logic             sh_start, sh_done;
    logic [7:0]       sh_tx, sh_rx;

    assign cnt_inc   = cnt_q + 1'b1;
    assign req_ready = (state_q == ST_IDLE);
    assign spi_cs_n  = (state_q == ST_IDLE) || (state_q == ST_WGAP) || (state_q == ST_TAIL);
    assign wr_ready  = (state_q == ST_DATA) && hdr_q.is_write && !inflight_q;

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        case (state_q)
            ST_WREN: begin sh_start = !inflight_q; sh_tx = OPC_WREN;                 end
            ST_OPC:  begin sh_start = !inflight_q; sh_tx = pick_opcode(hdr_q);       end
            ST_ADDR: begin sh_start = !inflight_q; sh_tx = addr_byte(hdr_q.addr, idx_q); end
            ST_DATA: begin
                if (hdr_q.is_write) begin
                    sh_start = !inflight_q && wr_valid;
                    sh_tx    = wr_data;
                end else begin
                    sh_start = !inflight_q && !rd_valid;
                end
            end
            default: ;
        endcase
    end

    nvm_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .start(sh_start),
        .tx   (sh_tx),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .done (sh_done),
        .rx   (sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            hdr_q      <= '0;
            len_q      <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
            gap_q      <= '0;
            inflight_q <= 1'b0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            done       <= 1'b0;
            done_count <= '0;
        end else begin
            done <= 1'b0;
            if (rd_valid && rd_ready) rd_valid <= 1'b0;
            if (sh_start) inflight_q <= 1'b1;
            if (sh_done)  inflight_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    hdr_q.is_write <= req_write;
                    hdr_q.compact  <= cfg_compact && (cfg_addr_m1 == 2'd0);
                    hdr_q.addr_m1  <= cfg_addr_m1;
                    hdr_q.addr     <= req_addr;
                    len_q          <= req_len;
                    cnt_q          <= '0;
                    state_q        <= req_write ? ST_WREN : ST_OPC;
                end
                ST_WREN: if (sh_done) begin
                    gap_q   <= '0;
                    state_q <= ST_WGAP;
                end
                ST_WGAP: begin
                    if (gap_q == GAP_LAST) state_q <= ST_OPC;
                    else                   gap_q   <= gap_q + 1'b1;
                end
                ST_OPC: if (sh_done) begin
                    idx_q   <= hdr_q.addr_m1;
                    state_q <= ST_ADDR;
                end
                ST_ADDR: if (sh_done) begin
                    if (idx_q != 2'd0) begin
                        idx_q <= idx_q - 1'b1;
                    end else if (len_q == '0) begin
                        state_q    <= ST_TAIL;
                        gap_q      <= '0;
                        done       <= 1'b1;
                        done_count <= '0;
                    end else begin
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: if (sh_done) begin
                    cnt_q <= cnt_inc;
                    if (!hdr_q.is_write) begin
                        rd_data  <= sh_rx;
                        rd_valid <= 1'b1;
                    end
                    if (cnt_inc == len_q) begin
                        state_q    <= ST_TAIL;
                        gap_q      <= '0;
                        done       <= 1'b1;
                        done_count <= cnt_inc;
                    end
                end
                ST_TAIL: begin
                    if (gap_q == GAP_LAST) state_q <= ST_IDLE;
                    else                   gap_q   <= gap_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: cycles chip-select has been high, saturating
    logic [GW-1:0] hi_q;
    always_ff @(posedge clk) begin
        if (rst)           hi_q <= GAP_FULL;
        else if (!spi_cs_n) hi_q <= '0;
        else if (hi_q != GAP_FULL) hi_q <= hi_q + 1'b1;
    end

    assert_cs_gap_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_q >= GAP_FULL));
    assert_idle_sck_low_R8: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);
    assert_done_cs_high_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n);
    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> spi_cs_n);
    assert_read_mosi_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !hdr_q.is_write) |-> !spi_mosi);
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/nvm_spi_seq_test.sv
module nvm_spi_seq_test;
    localparam int CNT_W = 16;
    localparam int DIV   = 2;
    localparam int GAP   = 16;

    typedef struct packed {
        logic        wr;
        logic [1:0]  am1;
        logic        cmp;
        logic [31:0] addr;
        logic [7:0]  len;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd1, 1'b0, 32'h0000_1234, 8'd3},
        '{1'b0, 2'd2, 1'b0, 32'h00AB_CDEF, 8'd4},
        '{1'b1, 2'd0, 1'b1, 32'h0000_01A5, 8'd2},
        '{1'b0, 2'd0, 1'b1, 32'h0000_007F, 8'd2},
        '{1'b0, 2'd3, 1'b0, 32'h89AB_CDEF, 8'd1},
        '{1'b0, 2'd0, 1'b0, 32'h0000_01A5, 8'd1},
        '{1'b1, 2'd3, 1'b0, 32'h0102_0304, 8'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, cfg_compact = 0;
    logic [31:0] req_addr = 0;
    logic [CNT_W-1:0] req_len = 0;
    logic [1:0] cfg_addr_m1 = 0;
    logic [7:0] wr_data = 0;
    logic wr_valid = 0, rd_ready = 0;
    logic req_ready, wr_ready, rd_valid, done, spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 0;
    logic [7:0] rd_data;
    logic [CNT_W-1:0] done_count;

    always #5 clk = ~clk;

    nvm_spi_seq #(.CNT_W(CNT_W), .CLK_DIV(DIV), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .cfg_addr_m1(cfg_addr_m1), .cfg_compact(cfg_compact),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .done(done), .done_count(done_count), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory-side model and bus monitor ----------------
    function automatic logic [7:0] slv_byte(int k);
        return 8'hC3 ^ 8'(k * 29);
    endfunction

    int fr_cnt = 0;
    int fr_len [16];
    logic [7:0] fr_b [16][48];
    int fr_gap [16];
    int bitn = 0, kbyte = 0, rises = 0, hicnt = 0;
    int mode_viol = 0, period_viol = 0;
    longint cyc = 0, last_rise = 0;
    logic [7:0] acc = 0;
    logic prev_sck = 0, prev_mosi = 0;

    always @(negedge spi_cs_n) begin
        if (fr_cnt < 16) fr_len[fr_cnt] = 0;
        bitn = 0; kbyte = 0;
        spi_miso = slv_byte(0)[7];
        fr_cnt++;
    end

    always @(posedge spi_sck) begin
        rises++;
        if (bitn > 0 && (cyc - last_rise) != 2 * DIV) period_viol++;
        last_rise = cyc;
        acc = {acc[6:0], spi_mosi};
        bitn++;
        if (bitn == 8) begin
            if (fr_cnt >= 1 && fr_cnt <= 16 && kbyte < 48) fr_b[fr_cnt-1][kbyte] = acc;
            if (fr_cnt >= 1 && fr_cnt <= 16) fr_len[fr_cnt-1]++;
            kbyte++;
            bitn = 0;
        end
    end

    always @(negedge spi_sck) spi_miso = slv_byte(kbyte)[7-bitn];

    always @(posedge clk) begin
        cyc++;
        if (prev_sck && spi_sck && (prev_mosi != spi_mosi)) mode_viol++;
        prev_sck = spi_sck;
        prev_mosi = spi_mosi;
        if (spi_cs_n) hicnt++;
        else begin
            if (hicnt != 0 && fr_cnt >= 1 && fr_cnt <= 16) fr_gap[fr_cnt-1] = hicnt;
            hicnt = 0;
        end
    end

    task automatic clear_log();
        fr_cnt = 0;
        for (int i = 0; i < 16; i++) begin fr_len[i] = 0; fr_gap[i] = 0; end
    endtask

    // ---------------- host side ----------------
    logic [7:0] got_rd [64];
    int got_n = 0;
    int last_count = 0;

    task automatic xfer(input vec_t v, input int vi, input bit stall, input bit noise);
        int idx = 0, scnt = 0, snap = 0;
        bit took = 0, fin = 0;
        got_n = 0;
        req_write = v.wr; req_addr = v.addr; req_len = CNT_W'(v.len);
        cfg_addr_m1 = v.am1; cfg_compact = v.cmp; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (noise) begin
            req_write = ~v.wr; req_addr = 32'hDEAD_BEEF; req_len = 5;
            cfg_addr_m1 = 2'd3; cfg_compact = 1'b1;
        end else req_valid = 0;
        for (int c = 0; c < 4000 && !fin; c++) begin
            if (took) idx++;
            if (v.wr) begin
                if (stall && idx == 1 && scnt < 60) begin
                    wr_valid = 0; scnt++;
                    if (scnt == 40) snap = rises;
                    if (scnt == 60) begin
                        chk(rises == snap, "R9", "write stall sck edges", rises, snap);
                        chk(spi_cs_n == 0, "R9", "cs during write stall", spi_cs_n, 0);
                    end
                end else wr_valid = (idx < v.len);
                wr_data = 8'h50 + 8'(idx) + 8'(vi * 16);
                took = wr_valid && wr_ready;
            end else begin
                if (stall && got_n == 0 && rd_valid && scnt < 60) begin
                    rd_ready = 0; scnt++;
                    if (scnt == 40) snap = rises;
                    if (scnt == 60) begin
                        chk(rises == snap, "R9", "read stall sck edges", rises, snap);
                        chk(spi_cs_n == 0, "R9", "cs during read stall", spi_cs_n, 0);
                        chk(rd_data == slv_byte(v.am1 + 2), "R9", "held rd_data",
                            rd_data, slv_byte(v.am1 + 2));
                    end
                end else rd_ready = 1;
                if (rd_valid && rd_ready && got_n < 64) begin
                    got_rd[got_n] = rd_data; got_n++;
                end
            end
            if (done) begin fin = 1; last_count = int'(done_count); end
            else @(negedge clk);
        end
        chk(fin, "R6", "transfer completion", fin, 1);
        req_valid = 0; wr_valid = 0;
        @(negedge clk);
        rd_ready = 0;
    endtask

    task automatic check_vector(input vec_t v, input int vi);
        logic [7:0] exp [48];
        int n = 0, naddr, f, bad = -1;
        logic [7:0] opc;
        bit cmp;
        naddr = int'(v.am1) + 1;
        cmp = v.cmp && v.am1 == 2'd0;
        opc = v.wr ? 8'h02 : 8'h03;
        if (cmp && v.addr > 32'hFF) opc = opc | 8'h08;
        exp[n++] = opc;
        for (int j = naddr - 1; j >= 0; j--) exp[n++] = v.addr[8*j +: 8];
        for (int i = 0; i < int'(v.len); i++)
            exp[n++] = v.wr ? 8'h50 + 8'(i) + 8'(vi * 16) : 8'h00;
        chk(fr_cnt == (v.wr ? 2 : 1), v.wr ? "R2" : "R3", "frame count", fr_cnt, v.wr ? 2 : 1);
        f = v.wr ? 1 : 0;
        if (v.wr) begin
            chk(fr_len[0] == 1 && fr_b[0][0] == 8'h06, "R2", "write-enable frame",
                fr_b[0][0], 8'h06);
            chk(fr_gap[1] >= GAP, "R2", "gap before write frame", fr_gap[1], GAP);
        end
        chk(fr_len[f] == n, v.len == 0 ? "R7" : "R6", "frame length", fr_len[f], n);
        for (int i = 0; i < n && i < fr_len[f]; i++)
            if (bad < 0 && fr_b[f][i] != exp[i]) bad = i;
        if (bad >= 0)
            chk(0, cmp ? "R5" : "R4", "frame byte", fr_b[f][bad], exp[bad]);
        else
            chk(1, cmp ? "R5" : "R4", "frame bytes", 0, 0);
        chk(last_count == int'(v.len), v.len == 0 ? "R7" : "R6", "done_count",
            last_count, v.len);
        if (!v.wr) begin
            bad = -1;
            for (int i = 0; i < int'(v.len); i++)
                if (bad < 0 && got_rd[i] != slv_byte(1 + naddr + i)) bad = i;
            chk(got_n == int'(v.len), "R8", "read byte count", got_n, v.len);
            if (bad >= 0) chk(0, "R8", "read data", got_rd[bad], slv_byte(1 + naddr + bad));
            else          chk(1, "R8", "read data", 0, 0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(spi_cs_n == 1, "R8", "reset cs_n", spi_cs_n, 1);
        chk(spi_sck == 0, "R8", "reset sck", spi_sck, 0);
        chk(req_ready == 1, "R10", "reset req_ready", req_ready, 1);
        chk(done == 0 && rd_valid == 0, "R6", "reset done/rd_valid", {done, rd_valid}, 0);

        for (int vi = 0; vi < NV; vi++) begin
            clear_log();
            xfer(VECS[vi], vi, 1'b0, 1'b1);
            repeat (GAP + 40) @(negedge clk);
            check_vector(VECS[vi], vi);
        end

        // R9: read stall with the first byte pending
        clear_log();
        xfer('{1'b0, 2'd0, 1'b0, 32'h10, 8'd3}, 0, 1'b1, 1'b0);
        repeat (GAP + 10) @(negedge clk);
        check_vector('{1'b0, 2'd0, 1'b0, 32'h10, 8'd3}, 0);

        // R9: write stall after the first byte
        clear_log();
        xfer('{1'b1, 2'd1, 1'b0, 32'h0321, 8'd3}, 2, 1'b1, 1'b0);
        repeat (GAP + 10) @(negedge clk);
        check_vector('{1'b1, 2'd1, 1'b0, 32'h0321, 8'd3}, 2);

        // R10: back-to-back requests keep the chip-select gap
        clear_log();
        xfer('{1'b0, 2'd0, 1'b0, 32'h22, 8'd1}, 0, 1'b0, 1'b0);
        xfer('{1'b0, 2'd0, 1'b0, 32'h23, 8'd1}, 0, 1'b0, 1'b0);
        repeat (GAP + 10) @(negedge clk);
        chk(fr_cnt == 2, "R10", "back-to-back frames", fr_cnt, 2);
        chk(fr_gap[1] >= GAP, "R10", "gap between requests", fr_gap[1], GAP);

        chk(mode_viol == 0, "R8", "mosi change while sck high", mode_viol, 0);
        chk(period_viol == 0, "R8", "sck period within byte", period_viol, 0);
        chk(spi_sck == 0 && spi_cs_n == 1, "R1", "bus idle at end", {spi_sck, spi_cs_n}, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule